// File: doc/BRIEF.md
# Multi-Sensor Thermal Sampling Controller

This block schedules periodic temperature measurements for up to eight sensors; four is the default. Software sets up the block through a 32-bit word-addressed register bus. It programs the acquisition window, the spacing of sample slots, the measurement period and an averaging depth. At the start of each measurement round, the block walks through the enabled sensors in ascending index order. For each sensor it holds the analog input in acquisition for a programmed number of clocks, then requests a conversion over a request/acknowledge handshake. It accumulates the returned raw codes over the averaging depth and stores the mean as that sensor's result word.

Storing a result sets that sensor's data-ready status bit. A single interrupt line is raised while any status bit is set and also enabled. The calibration words are plain storage for software and feed no arithmetic. The analog front end and its converter lie outside the block. They answer `conv_req` with `conv_ack` and a raw code.

Top module: `tsense_ctrl`

## Requirements
- R1: After reset, the registers read as follows:
  - timing word (0x00): 0x01DF_002F;
  - period word (0x04): 365 in bits 31:12;
  - filter word (0x08): 0x5;
  - sensor enable (0x0C): 0;
  - interrupt enable (0x10): 0;
  - interrupt status (0x14): 0.
  
  `irq` is low after reset.
- R2: The timing word holds the acquire count minus one in bits 15:0 and the slot count minus one in bits 31:16. For a field value a, `acq_hold` stays high for a+1 clocks, and `conv_req` rises in the next clock. For a slot field s, successive conversion requests for one sensor start s+1 clocks apart whenever each conversion finishes inside its slot.
- R3: With period field x (bits 31:12 of 0x04), averaging depth D and the block's time unit U, a round starts every (x+1)·U·D clocks. U is 4096 by default.
- R4: The filter word has an enable in bit 2 and a type t in bits 1:0. When enabled, D = 2^(t+1), so t=1 means 4 samples. When disabled, D = 1. The stored result is the sum of the D codes shifted right by log2 D.
- R5: Only sensors whose bit i is set in the enable mask are sampled. A disabled sensor gets no request and no status bit. Within a round, sensors are visited in ascending index, and each sensor's D samples are taken back to back.
- R6: Sensor i's result reads at 0x40+4·i, zero-extended. It reads 0 until its first result is stored. It changes only when a new result for that sensor is stored.
- R7: Calibration word k at 0x20+4·k holds sensor 2k in bits 11:0 and sensor 2k+1 in bits 27:16. Both fields reset to 0x800, and all other bits read 0. The values are held only.
- R8: The interrupt status at 0x14 has bit i for sensor i. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: Storing a result sets that sensor's status bit, and the set wins over a clear in the same clock. `irq` is high exactly when some status bit is set together with its bit in the interrupt enable at 0x10.
- R10: `conv_req` and `conv_sel` hold steady until `conv_ack`. The code is captured only in the clock that `conv_ack` is high, so a late acknowledge stretches the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| acq_hold | output | 1 | Front end is in acquisition |
| conv_req | output | 1 | Conversion request |
| conv_sel | output | IDX_W | Sensor index of the current request |
| conv_ack | input | 1 | Conversion done, code valid this clock |
| conv_code | input | CODE_W | Raw converter code |
| irq | output | 1 | Data-ready interrupt |

## Verification
The assertions check several properties on every clock:
- acquisition and conversion never overlap, and a request is always preceded by acquisition;
- a request and its sensor index hold until acknowledged;
- every stored result sets its status bit;
- a one-write clears a status bit unless a result lands in the same clock;
- result words never change without a store.

Other behaviours can only be shown by the bench's scenarios, with expected values computed arithmetically:
- the averaged values for every filter depth;
- the exact round period;
- the acquire and slot lengths;
- the ascending visiting order;
- the absence of activity on masked sensors.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

   localparam int BUS_AW       = 8;
   localparam int CAL_W        = 12;
   localparam int MAX_DEPTH_LG = 4;

   localparam logic [BUS_AW-1:0] A_TIMING  = 8'h00;
   localparam logic [BUS_AW-1:0] A_PERIOD  = 8'h04;
   localparam logic [BUS_AW-1:0] A_FILTER  = 8'h08;
   localparam logic [BUS_AW-1:0] A_SENS_EN = 8'h0C;
   localparam logic [BUS_AW-1:0] A_IRQ_EN  = 8'h10;
   localparam logic [BUS_AW-1:0] A_IRQ_STS = 8'h14;
   localparam logic [BUS_AW-1:0] A_CAL     = 8'h20;
   localparam logic [BUS_AW-1:0] A_DATA    = 8'h40;

   localparam logic [15:0]    RST_ACQ   = 16'd47;
   localparam logic [15:0]    RST_SLOT  = 16'd479;
   localparam logic [19:0]    RST_PER   = 20'd365;
   localparam logic [CAL_W-1:0] RST_CAL = 12'h800;

   typedef struct packed {
      logic [15:0] acq;
      logic [15:0] slot;
      logic [19:0] per;
      logic        filt_en;
      logic [1:0]  filt_type;
   } tsense_cfg_t;

   typedef enum logic [2:0] {
      S_IDLE, S_PICK, S_ACQ, S_CONV, S_GAP, S_STORE
   } tsense_st_e;

endpackage

// File: rtl/tsense_regs.sv
module tsense_regs
   import tsense_pkg::*;
#(
   parameter int NSENS  = 4,
   parameter int CODE_W = 12,
   parameter int IDX_W  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_sel,
   input  logic                    bus_wr,
   input  logic [BUS_AW-1:0]       bus_addr,
   input  logic [31:0]             bus_wdata,
   output logic [31:0]             bus_rdata,
   output tsense_cfg_t             cfg,
   output logic [NSENS-1:0]        sens_en,
   input  logic                    res_we,
   input  logic [IDX_W-1:0]        res_idx,
   input  logic [CODE_W-1:0]       res_val,
   output logic [NSENS-1:0]        sts,
   output logic [NSENS*CODE_W-1:0] data_flat,
   output logic                    irq
);

   localparam int NCAL = (NSENS + 1) / 2;

   logic                wr;
   logic [NSENS-1:0]    ien_q;
   logic [NSENS-1:0]    en_q;
   tsense_cfg_t         cfg_q;
   logic [CAL_W-1:0]    cal_lo [NCAL];
   logic [CAL_W-1:0]    cal_hi [NCAL];
   logic [CODE_W-1:0]   data_w [NSENS];

   assign wr = bus_sel & bus_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q.acq       <= RST_ACQ;
         cfg_q.slot      <= RST_SLOT;
         cfg_q.per       <= RST_PER;
         cfg_q.filt_en   <= 1'b1;
         cfg_q.filt_type <= 2'd1;
         en_q            <= '0;
         ien_q           <= '0;
      end else if (wr) begin
         case (bus_addr)
            A_TIMING: begin
               cfg_q.acq  <= bus_wdata[15:0];
               cfg_q.slot <= bus_wdata[31:16];
            end
            A_PERIOD: cfg_q.per <= bus_wdata[31:12];
            A_FILTER: begin
               cfg_q.filt_en   <= bus_wdata[2];
               cfg_q.filt_type <= bus_wdata[1:0];
            end
            A_SENS_EN: en_q  <= bus_wdata[NSENS-1:0];
            A_IRQ_EN:  ien_q <= bus_wdata[NSENS-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NCAL; k++) begin
            cal_lo[k] <= RST_CAL;
            cal_hi[k] <= RST_CAL;
         end
      end else begin
         for (int k = 0; k < NCAL; k++) begin
            if (wr && bus_addr == A_CAL + BUS_AW'(4 * k)) begin
               cal_lo[k] <= bus_wdata[CAL_W-1:0];
               cal_hi[k] <= bus_wdata[16+CAL_W-1:16];
            end
         end
      end
   end

   // one status bit and one result word per sensor
   for (genvar i = 0; i < NSENS; i++) begin : g_sens
      logic              sts_b;
      logic [CODE_W-1:0] data_q;
      logic              hit;
      logic              clr;

      assign hit = res_we && (res_idx == IDX_W'(i));
      assign clr = wr && (bus_addr == A_IRQ_STS) && bus_wdata[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sts_b  <= 1'b0;
            data_q <= '0;
         end else begin
            if (hit) begin
               sts_b  <= 1'b1;
               data_q <= res_val;
            end else if (clr) begin
               sts_b <= 1'b0;
            end
         end
      end

      assign sts[i]                          = sts_b;
      assign data_w[i]                       = data_q;
      assign data_flat[i*CODE_W +: CODE_W]   = data_q;
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_TIMING:  bus_rdata = {cfg_q.slot, cfg_q.acq};
         A_PERIOD:  bus_rdata = {cfg_q.per, 12'b0};
         A_FILTER:  bus_rdata = {29'b0, cfg_q.filt_en, cfg_q.filt_type};
         A_SENS_EN: bus_rdata[NSENS-1:0] = en_q;
         A_IRQ_EN:  bus_rdata[NSENS-1:0] = ien_q;
         A_IRQ_STS: bus_rdata[NSENS-1:0] = sts;
         default: ;
      endcase
      for (int k = 0; k < NCAL; k++) begin
         if (bus_addr == A_CAL + BUS_AW'(4 * k))
            bus_rdata = {4'b0, cal_hi[k], 4'b0, cal_lo[k]};
      end
      for (int i = 0; i < NSENS; i++) begin
         if (bus_addr == A_DATA + BUS_AW'(4 * i))
            bus_rdata = 32'(data_w[i]);
      end
   end

   assign cfg     = cfg_q;
   assign sens_en = en_q;
   assign irq     = |(sts & ien_q);

endmodule

// File: rtl/tsense_pacer.sv
module tsense_pacer
   import tsense_pkg::*;
#(
   parameter int UNIT_LG = 12
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [19:0] per_x,
   input  logic [2:0]  dep_lg,
   output logic        tick
);

   localparam int CNT_W = 21 + UNIT_LG + MAX_DEPTH_LG;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   // (x+1) * 2^UNIT_LG * 2^dep_lg - 1
   always_comb limit = ((CNT_W'(per_x) + CNT_W'(1)) << (UNIT_LG + int'(dep_lg))) - CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (cnt_q >= limit) begin
         cnt_q <= '0;
         tick  <= 1'b1;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
         tick  <= 1'b0;
      end
   end

endmodule

// File: rtl/tsense_seq.sv
module tsense_seq
   import tsense_pkg::*;
#(
   parameter int NSENS  = 4,
   parameter int CODE_W = 12,
   parameter int IDX_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic [NSENS-1:0]   sens_en,
   input  logic [15:0]        acq_cfg,
   input  logic [15:0]        slot_cfg,
   input  logic [2:0]         dep_lg,
   output logic               acq_hold,
   output logic               conv_req,
   output logic [IDX_W-1:0]   conv_sel,
   input  logic               conv_ack,
   input  logic [CODE_W-1:0]  conv_code,
   output logic               res_we,
   output logic [IDX_W-1:0]   res_idx,
   output logic [CODE_W-1:0]  res_val
);

   localparam int ACC_W = CODE_W + MAX_DEPTH_LG;

   tsense_st_e                st_q;
   logic [NSENS-1:0]          mask_q;
   logic [IDX_W-1:0]          sel_q;
   logic [IDX_W-1:0]          nxt_idx;
   logic [MAX_DEPTH_LG-1:0]   samp_q;
   logic [MAX_DEPTH_LG-1:0]   last_samp;
   logic [2:0]                lg_q;
   logic [ACC_W-1:0]          acc_q;
   logic [15:0]               slot_q;
   logic [15:0]               acq_q;
   logic [15:0]               acq_f;
   logic [15:0]               slot_f;
   logic [15:0]               slot_inc;

   always_comb begin
      nxt_idx = '0;
      for (int i = NSENS - 1; i >= 0; i--)
         if (mask_q[i]) nxt_idx = IDX_W'(i);
   end

   assign last_samp = MAX_DEPTH_LG'((5'd1 << lg_q) - 5'd1);
   assign slot_inc  = (slot_q == 16'hFFFF) ? slot_q : slot_q + 16'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         mask_q <= '0;
         sel_q  <= '0;
         samp_q <= '0;
         lg_q   <= '0;
         acc_q  <= '0;
         slot_q <= '0;
         acq_q  <= '0;
         acq_f  <= '0;
         slot_f <= '0;
      end else begin
         case (st_q)
            S_IDLE: begin
               if (tick && |sens_en) begin
                  mask_q <= sens_en;
                  acq_f  <= acq_cfg;
                  slot_f <= slot_cfg;
                  lg_q   <= dep_lg;
                  st_q   <= S_PICK;
               end
            end
            S_PICK: begin
               if (mask_q == '0) begin
                  st_q <= S_IDLE;
               end else begin
                  sel_q           <= nxt_idx;
                  mask_q[nxt_idx] <= 1'b0;
                  acc_q           <= '0;
                  samp_q          <= '0;
                  slot_q          <= '0;
                  acq_q           <= '0;
                  st_q            <= S_ACQ;
               end
            end
            S_ACQ: begin
               slot_q <= slot_inc;
               if (acq_q == acq_f) st_q <= S_CONV;
               else                acq_q <= acq_q + 16'd1;
            end
            S_CONV: begin
               slot_q <= slot_inc;
               if (conv_ack) begin
                  acc_q <= acc_q + ACC_W'(conv_code);
                  st_q  <= S_GAP;
               end
            end
            S_GAP: begin
               if (slot_q >= slot_f) begin
                  if (samp_q == last_samp) begin
                     st_q <= S_STORE;
                  end else begin
                     samp_q <= samp_q + 1'b1;
                     slot_q <= '0;
                     acq_q  <= '0;
                     st_q   <= S_ACQ;
                  end
               end else begin
                  slot_q <= slot_inc;
               end
            end
            S_STORE: st_q <= S_PICK;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign acq_hold = (st_q == S_ACQ);
   assign conv_req = (st_q == S_CONV);
   assign conv_sel = sel_q;
   assign res_we   = (st_q == S_STORE);
   assign res_idx  = sel_q;
   assign res_val  = CODE_W'(acc_q >> lg_q);

endmodule

// File: rtl/tsense_ctrl.sv
module tsense_ctrl
   import tsense_pkg::*;
#(
   parameter int NUM_SENS = 4,
   parameter int CODE_W   = 12,
   parameter int UNIT_LG  = 12,
   localparam int IDX_W   = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [7:0]         bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               acq_hold,
   output logic               conv_req,
   output logic [IDX_W-1:0]   conv_sel,
   input  logic               conv_ack,
   input  logic [CODE_W-1:0]  conv_code,
   output logic               irq
);

   if (NUM_SENS < 1 || NUM_SENS > 8) begin : g_bad_nsens
      $error("tsense_ctrl: NUM_SENS must lie in 1..8");
   end
   if (CODE_W < 1 || CODE_W > 16) begin : g_bad_code
      $error("tsense_ctrl: CODE_W must lie in 1..16");
   end
   if (UNIT_LG < 0 || UNIT_LG > 16) begin : g_bad_unit
      $error("tsense_ctrl: UNIT_LG must lie in 0..16");
   end

   tsense_cfg_t                  cfg;
   logic [NUM_SENS-1:0]          sens_en;
   logic [NUM_SENS-1:0]          sts_vec;
   logic [NUM_SENS*CODE_W-1:0]   data_vec;
   logic                         res_we;
   logic [IDX_W-1:0]             res_idx;
   logic [CODE_W-1:0]            res_val;
   logic                         tick;
   logic [2:0]                   dep_lg;

   assign dep_lg = cfg.filt_en ? (3'(cfg.filt_type) + 3'd1) : 3'd0;

   tsense_regs #(.NSENS(NUM_SENS), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cfg       (cfg),
      .sens_en   (sens_en),
      .res_we    (res_we),
      .res_idx   (res_idx),
      .res_val   (res_val),
      .sts       (sts_vec),
      .data_flat (data_vec),
      .irq       (irq)
   );

   tsense_pacer #(.UNIT_LG(UNIT_LG)) u_pacer (
      .clk    (clk),
      .rst_n  (rst_n),
      .per_x  (cfg.per),
      .dep_lg (dep_lg),
      .tick   (tick)
   );

   tsense_seq #(.NSENS(NUM_SENS), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .sens_en   (sens_en),
      .acq_cfg   (cfg.acq),
      .slot_cfg  (cfg.slot),
      .dep_lg    (dep_lg),
      .acq_hold  (acq_hold),
      .conv_req  (conv_req),
      .conv_sel  (conv_sel),
      .conv_ack  (conv_ack),
      .conv_code (conv_code),
      .res_we    (res_we),
      .res_idx   (res_idx),
      .res_val   (res_val)
   );

endmodule

// File: rtl/tsense_ctrl_chk.sv
module tsense_ctrl_chk
   import tsense_pkg::*;
#(
   parameter int NSENS  = 4,
   parameter int CODE_W = 12,
   parameter int IDX_W  = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    bus_sel,
   input logic                    bus_wr,
   input logic [7:0]              bus_addr,
   input logic [NSENS-1:0]        clr_bits,
   input logic                    acq_hold,
   input logic                    conv_req,
   input logic [IDX_W-1:0]        conv_sel,
   input logic                    conv_ack,
   input logic                    res_we,
   input logic [IDX_W-1:0]        res_idx,
   input logic [NSENS-1:0]        sts,
   input logic [NSENS*CODE_W-1:0] data_flat
);

   // R2
   phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(acq_hold && conv_req));

   // R2
   acq_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_req) |-> $past(acq_hold));

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && !conv_ack) |=> (conv_req && $stable(conv_sel)));

   // R9
   sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_we |=> sts[$past(res_idx)]);

   // R6
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_we |=> $stable(data_flat));

   for (genvar i = 0; i < NSENS; i++) begin : g_w1c
      // R8
      w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && bus_wr && bus_addr == A_IRQ_STS && clr_bits[i]
          && !(res_we && res_idx == IDX_W'(i))) |=> !sts[i]);
   end

endmodule

bind tsense_ctrl tsense_ctrl_chk #(.NSENS(NUM_SENS), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .clr_bits  (bus_wdata[NUM_SENS-1:0]),
   .acq_hold  (acq_hold),
   .conv_req  (conv_req),
   .conv_sel  (conv_sel),
   .conv_ack  (conv_ack),
   .res_we    (res_we),
   .res_idx   (res_idx),
   .sts       (sts_vec),
   .data_flat (data_vec)
);

// File: tb/tsense_ctrl_test.sv
module tsense_ctrl_test;
   import tsense_pkg::*;

   localparam int NS  = 4;
   localparam int CW  = 12;
   localparam int ULG = 4;
   localparam int PX  = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        acq_hold;
   logic        conv_req;
   logic [1:0]  conv_sel;
   logic        conv_ack = 1'b0;
   logic [CW-1:0] conv_code = 12'hABC;
   logic        irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // sensor model state
   int cur_lg = 0, pat_g = 0, lat_g = 1;
   int mj [NS];
   int req_cnt [NS];
   int j0_cnt [NS];
   int j0_prev [NS];
   int j0_last [NS];
   int last_rise = 0, last_sel = 0, spc_last = 0;
   bit order_err = 0;
   int acq_run = 0, acq_len = 0;
   int exp_data [NS];

   tsense_ctrl #(.NUM_SENS(NS), .CODE_W(CW), .UNIT_LG(ULG)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .acq_hold(acq_hold), .conv_req(conv_req), .conv_sel(conv_sel),
      .conv_ack(conv_ack), .conv_code(conv_code), .irq(irq)
   );

   always #10 clk = ~clk;

   initial forever begin
      @(posedge clk);
      cyc++;
   end

   function automatic int code_of(int s, int j, int p);
      return (p * 389 + s * 613 + j * 97 + 5) % 4096;
   endfunction

   function automatic int exp_avg(int s, int p, int lg);
      int sum = 0;
      for (int j = 0; j < (1 << lg); j++) sum += code_of(s, j, p);
      return sum >> lg;
   endfunction

   // converter model: acknowledges lat_g clocks after seeing a request
   initial begin
      bit in_req = 0;
      int wait_n = 0;
      for (int i = 0; i < NS; i++) begin
         mj[i] = 0; req_cnt[i] = 0; j0_cnt[i] = 0; j0_prev[i] = 0; j0_last[i] = 0;
      end
      forever begin
         @(negedge clk);
         if (acq_hold) acq_run++;
         else if (acq_run > 0) begin acq_len = acq_run; acq_run = 0; end
         if (conv_ack) begin
            conv_ack = 1'b0;
            conv_code = 12'hABC;
         end else if (conv_req) begin
            int s;
            s = int'(conv_sel);
            if (!in_req) begin
               in_req = 1; wait_n = 0;
               req_cnt[s]++;
               if (mj[s] == 0) begin
                  j0_prev[s] = j0_last[s]; j0_last[s] = cyc; j0_cnt[s]++;
               end else begin
                  spc_last = cyc - last_rise;
               end
               if (s < last_sel && (cyc - last_rise) < 40) order_err = 1;
               last_rise = cyc; last_sel = s;
            end
            if (wait_n >= lat_g) begin
               conv_ack = 1'b1;
               conv_code = CW'(code_of(s, mj[s], pat_g));
               mj[s] = (mj[s] + 1) % (1 << cur_lg);
               in_req = 0;
            end else begin
               wait_n++;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #2 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic run_case(input bit fen, input int ft, input logic [3:0] mask, input int pat, input int lat);
      logic [31:0] v;
      int lg, n, s0, c;
      wr(A_SENS_EN, 32'h0);
      repeat (1500) @(negedge clk);
      lg = fen ? ft + 1 : 0;
      cur_lg = lg; pat_g = pat; lat_g = lat;
      for (int i = 0; i < NS; i++) begin mj[i] = 0; req_cnt[i] = 0; end
      order_err = 0; spc_last = 0; acq_len = 0;
      wr(A_FILTER, {29'b0, fen, 2'(ft)});
      wr(A_IRQ_STS, 32'hF);
      wr(A_SENS_EN, {28'b0, mask});
      n = 0;
      do begin rd(A_IRQ_STS, v); n++; end while (((v[3:0] & mask) != mask) && n < 20000);
      chk((v[3:0] & mask) == mask, "R9 status set after round", v, {28'b0, mask});
      chk((v[3:0] & ~mask) == 0, "R5 no status for masked sensor", v, {28'b0, mask});
      for (int i = 0; i < NS; i++) begin
         if (mask[i]) exp_data[i] = exp_avg(i, pat, lg);
         rd(A_DATA + 8'(4 * i), v);
         chk(v == 32'(exp_data[i]), "R4 R6 averaged result", v, 32'(exp_data[i]));
         if (!mask[i]) chk(req_cnt[i] == 0, "R5 masked sensor requested", 32'(req_cnt[i]), 0);
      end
      chk(irq == 1'b0, "R9 irq masked by enable", {31'b0, irq}, 0);
      s0 = 0;
      for (int i = NS - 1; i >= 0; i--) if (mask[i]) s0 = i;
      c = j0_cnt[s0]; n = 0;
      while (j0_cnt[s0] < c + 2 && n < 20000) begin @(negedge clk); n++; end
      chk(j0_last[s0] - j0_prev[s0] == ((PX + 1) << (ULG + lg)), "R3 round period",
          32'(j0_last[s0] - j0_prev[s0]), 32'((PX + 1) << (ULG + lg)));
      chk(acq_len == 3, "R2 acquire length", 32'(acq_len), 3);
      if (lg > 0 && lat <= 2) chk(spc_last == 10, "R2 slot spacing", 32'(spc_last), 10);
      chk(!order_err, "R5 ascending order", {31'b0, order_err}, 0);
   endtask

   initial begin
      logic [31:0] v;
      for (int i = 0; i < NS; i++) exp_data[i] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      rd(A_TIMING, v);  chk(v == 32'h01DF_002F, "R1 timing reset", v, 32'h01DF_002F);
      rd(A_PERIOD, v);  chk(v == (32'd365 << 12), "R1 period reset", v, 32'd365 << 12);
      rd(A_FILTER, v);  chk(v == 32'h5, "R1 filter reset", v, 32'h5);
      rd(A_SENS_EN, v); chk(v == 0, "R1 enable reset", v, 0);
      rd(A_IRQ_EN, v);  chk(v == 0, "R1 irq enable reset", v, 0);
      rd(A_IRQ_STS, v); chk(v == 0, "R1 status reset", v, 0);
      chk(irq == 1'b0, "R1 irq reset", {31'b0, irq}, 0);
      // R7 calibration
      for (int k = 0; k < 2; k++) begin
         rd(A_CAL + 8'(4 * k), v); chk(v == 32'h0800_0800, "R7 cal reset", v, 32'h0800_0800);
      end
      wr(A_CAL, 32'hFFFF_FFFF);
      rd(A_CAL, v); chk(v == 32'h0FFF_0FFF, "R7 cal field widths", v, 32'h0FFF_0FFF);
      wr(A_CAL + 8'h4, 32'h0123_0456);
      rd(A_CAL + 8'h4, v); chk(v == 32'h0123_0456, "R7 cal odd/even fields", v, 32'h0123_0456);
      // R6 zero before first result
      for (int i = 0; i < NS; i++) begin
         rd(A_DATA + 8'(4 * i), v); chk(v == 0, "R6 data zero before result", v, 0);
      end
      wr(A_TIMING, {16'd9, 16'd2});
      wr(A_PERIOD, 32'(PX) << 12);
      run_case(1'b0, 0, 4'b1111, 1, 1);
      run_case(1'b1, 0, 4'b0101, 2, 1);
      run_case(1'b1, 1, 4'b1010, 3, 1);
      run_case(1'b1, 2, 4'b0001, 4, 0);
      run_case(1'b1, 3, 4'b1111, 5, 1);
      run_case(1'b1, 1, 4'b0110, 6, 15);   // R10 late acknowledge
      run_case(1'b1, 0, 4'b1111, 7, 1);
      // R8 / R9 status and interrupt
      wr(A_SENS_EN, 32'h0);
      repeat (1500) @(negedge clk);
      rd(A_IRQ_STS, v); chk(v == 32'hF, "R9 all status set", v, 32'hF);
      wr(A_IRQ_STS, 32'h0);
      rd(A_IRQ_STS, v); chk(v == 32'hF, "R8 write zero keeps status", v, 32'hF);
      wr(A_IRQ_STS, 32'h2);
      rd(A_IRQ_STS, v); chk(v == 32'hD, "R8 write one clears bit", v, 32'hD);
      rd(A_DATA + 8'h4, v); chk(v == 32'(exp_data[1]), "R6 data kept after clear", v, 32'(exp_data[1]));
      wr(A_IRQ_EN, 32'h2);
      @(negedge clk); chk(irq == 1'b0, "R9 irq off for cleared bit", {31'b0, irq}, 0);
      wr(A_IRQ_EN, 32'h4);
      @(negedge clk); chk(irq == 1'b1, "R9 irq on for enabled set bit", {31'b0, irq}, 1);
      wr(A_IRQ_STS, 32'h4);
      @(negedge clk); chk(irq == 1'b0, "R8 R9 irq drops after clear", {31'b0, irq}, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wait (cyc >= 180000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<180000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule